// File: doc/BRIEF.md
# Execution Timing Trace Capture Unit

This unit sits next to a monitored processor and listens to a decoded-instruction event port. Each event carries a 5-bit operation code together with the processor's current program counter and process ID. A free-running cycle timestamp arrives on a separate input. Four codes control the unit: claim ownership, start tracing, stop tracing and drop a timing mark. A mark records the timestamp and the program counter relative to a base address that was captured when ownership was claimed. Marks are stored in a private 4 KB scratchpad that only the monitor side can read.

The scratchpad has two areas. A small header at the bottom holds the owner process ID, the base address, the head and tail slot indices and a sticky overflow flag. Above it, the record area is a ring of 16-byte slots from byte offset 0x8A0 to 0xFF0, which gives 118 slots. The producer advances the head. After each controller run, the monitor reads the slots from tail up to head and then writes a new tail index through its own port.

Top module: `tt_capture`

## Requirements
- R1: Event codes are 1 = claim ownership, 2 = start tracing, 3 = stop tracing and 4 = timing mark. Every other code (0 and 5 to 31) changes no header field, no slot and no tracing state.
- R2: A claim that is accepted stores the event's process ID at byte offset 0x000 (zero-extended) and stores the event's program counter as the base address at offset 0x004.
- R3: While an owner is registered, start, stop and mark events from any other process ID have no effect.
- R4: A mark accepted while tracing writes the slot at the head index. The slot word at 0x8A0 + 16*head holds the timestamp, the word at +4 holds the program counter minus the base in 32-bit two's complement, and the words at +8 and +12 read as zero. The head index then advances by one.
- R5: A mark that arrives while tracing is stopped writes nothing and leaves the head unchanged.
- R6: The head index (offset 0x008) wraps from 117 to 0.
- R7: When advancing the head would make it equal to the tail, the mark is dropped and the head is kept. The overflow flag (offset 0x010, bit 0) is set and stays set until reset.
- R8: A tail write with a value below 118 sets the tail index (offset 0x00C). A tail write with a larger value is ignored.
- R9: After reset the unit has no owner and tracing is stopped. The header reads all zero: owner, base, head, tail and overflow.
- R10: A read returns its data on rd_data one clock after rd_en. A misaligned address, or an address outside the header words and the record area, reads zero.
- R11: While an owner is registered, a claim from a different process ID is ignored. A claim from the owner itself re-latches the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| evt_valid | input | 1 | instruction event present this cycle |
| evt_code | input | 5 | event operation code |
| evt_pc | input | 32 | program counter of the event |
| evt_pid | input | 16 | process ID of the event |
| tstamp | input | 32 | free-running cycle timestamp |
| rd_en | input | 1 | monitor read strobe |
| rd_addr | input | 12 | scratchpad byte address |
| rd_data | output | 32 | read data, one cycle after rd_en |
| tail_we | input | 1 | monitor tail update strobe |
| tail_wdata | input | 32 | new tail slot index |

## Verification
An event sampled at a clock edge updates the header and the slot at that same edge. A read issued on the following edge returns the updated value one more edge later. The bench therefore drives every event or tail write at a falling edge and issues the read at the next falling edge. It compares rd_data at the falling edge after that, so each expected value sits between two registers and no edge race is involved. Expected values come from a model inside the bench that is updated at the moment each stimulus is driven.

// File: rtl/tt_pkg.sv
package tt_pkg;
   localparam int TT_W = 32;

   typedef enum logic [4:0] {
      TT_NOP   = 5'd0,
      TT_CLAIM = 5'd1,
      TT_START = 5'd2,
      TT_STOP  = 5'd3,
      TT_MARK  = 5'd4
   } tt_op_e;

   typedef struct packed {
      logic [TT_W-1:0] ts;
      logic [TT_W-1:0] rel;
   } tt_rec_t;
endpackage

// File: rtl/tt_evt_decode.sv
module tt_evt_decode
   import tt_pkg::*;
#(
   parameter int PID_W = 16
) (
   input  logic             evt_valid,
   input  logic [4:0]       evt_code,
   input  logic [PID_W-1:0] evt_pid,
   input  logic             owned,
   input  logic [PID_W-1:0] owner_pid,
   input  logic             trace_on,
   output logic             do_claim,
   output logic             do_start,
   output logic             do_stop,
   output logic             do_mark
);
   logic owner_ok;

   assign owner_ok = !owned || (evt_pid == owner_pid);

   always_comb begin
      do_claim = 1'b0;
      do_start = 1'b0;
      do_stop  = 1'b0;
      do_mark  = 1'b0;
      if (evt_valid && owner_ok) begin
         case (evt_code)
            TT_CLAIM: do_claim = 1'b1;
            TT_START: do_start = 1'b1;
            TT_STOP:  do_stop  = 1'b1;
            TT_MARK:  do_mark  = trace_on;
            default:  ;
         endcase
      end
   end
endmodule

// File: rtl/tt_trace_ring.sv
module tt_trace_ring
   import tt_pkg::*;
#(
   parameter int N_SLOTS = 118,
   localparam int IDX_W  = $clog2(N_SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  tt_rec_t          push_rec,
   input  logic             tail_we,
   input  logic [TT_W-1:0]  tail_wdata,
   input  logic [IDX_W-1:0] rd_slot,
   output tt_rec_t          rd_rec,
   output logic [IDX_W-1:0] head,
   output logic [IDX_W-1:0] tail,
   output logic             ovf
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SLOTS - 1);

   tt_rec_t          slots [N_SLOTS];
   logic [IDX_W-1:0] head_nxt;
   logic             full;

   assign head_nxt = (head == LAST_IDX) ? '0 : head + 1'b1;
   assign full     = (head_nxt == tail);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head <= '0;
         tail <= '0;
         ovf  <= 1'b0;
      end else begin
         if (push) begin
            if (full) ovf  <= 1'b1;
            else      head <= head_nxt;
         end
         if (tail_we && (tail_wdata < TT_W'(N_SLOTS)))
            tail <= IDX_W'(tail_wdata);
      end
   end

   always_ff @(posedge clk) begin
      if (push && !full) slots[head] <= push_rec;
   end

   assign rd_rec = slots[rd_slot];
endmodule

// File: rtl/tt_capture.sv
module tt_capture
   import tt_pkg::*;
#(
   parameter int PID_W      = 16,
   parameter int ADDR_W     = 12,
   parameter int REC_BASE   = 'h8A0,
   parameter int REC_LAST   = 'hFF0,
   parameter int SLOT_BYTES = 16,
   localparam int SLOT_SH   = $clog2(SLOT_BYTES),
   localparam int N_SLOTS   = (REC_LAST - REC_BASE) / SLOT_BYTES + 1,
   localparam int IDX_W     = $clog2(N_SLOTS),
   localparam int REC_END   = REC_LAST + SLOT_BYTES - 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [4:0]        evt_code,
   input  logic [TT_W-1:0]   evt_pc,
   input  logic [PID_W-1:0]  evt_pid,
   input  logic [TT_W-1:0]   tstamp,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [TT_W-1:0]   rd_data,
   input  logic              tail_we,
   input  logic [TT_W-1:0]   tail_wdata
);
   if (PID_W < 1 || PID_W > TT_W) begin : g_bad_pid
      $error("tt_capture: PID_W must be 1..32");
   end
   if ((1 << SLOT_SH) != SLOT_BYTES || SLOT_BYTES < 8) begin : g_bad_slot
      $error("tt_capture: SLOT_BYTES must be a power of two of at least 8");
   end
   if (REC_BASE % SLOT_BYTES != 0 || REC_BASE < 32 || REC_END >= (1 << ADDR_W)) begin : g_bad_area
      $error("tt_capture: record area misplaced");
   end

   logic             owned;
   logic [PID_W-1:0] owner_pid;
   logic [TT_W-1:0]  base_pc;
   logic             trace_on;
   logic             do_claim, do_start, do_stop, do_mark;
   tt_rec_t          push_rec, rd_rec;
   logic [IDX_W-1:0] head, tail, rd_slot;
   logic             ovf;
   logic [TT_W-1:0]  pid_word, rd_next;
   logic             in_rec;

   tt_evt_decode #(.PID_W(PID_W)) u_dec (
      .evt_valid (evt_valid),
      .evt_code  (evt_code),
      .evt_pid   (evt_pid),
      .owned     (owned),
      .owner_pid (owner_pid),
      .trace_on  (trace_on),
      .do_claim  (do_claim),
      .do_start  (do_start),
      .do_stop   (do_stop),
      .do_mark   (do_mark)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owned     <= 1'b0;
         owner_pid <= '0;
         base_pc   <= '0;
         trace_on  <= 1'b0;
      end else begin
         if (do_claim) begin
            owned     <= 1'b1;
            owner_pid <= evt_pid;
            base_pc   <= evt_pc;
         end
         if (do_start)     trace_on <= 1'b1;
         else if (do_stop) trace_on <= 1'b0;
      end
   end

   assign push_rec.ts  = tstamp;
   assign push_rec.rel = evt_pc - base_pc;

   tt_trace_ring #(.N_SLOTS(N_SLOTS)) u_ring (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (do_mark),
      .push_rec   (push_rec),
      .tail_we    (tail_we),
      .tail_wdata (tail_wdata),
      .rd_slot    (rd_slot),
      .rd_rec     (rd_rec),
      .head       (head),
      .tail       (tail),
      .ovf        (ovf)
   );

   if (PID_W == TT_W) begin : g_pid_full
      assign pid_word = owner_pid;
   end else begin : g_pid_pad
      assign pid_word = {{(TT_W-PID_W){1'b0}}, owner_pid};
   end

   assign in_rec  = (int'(rd_addr) >= REC_BASE) && (int'(rd_addr) <= REC_END);
   assign rd_slot = IDX_W'((rd_addr - ADDR_W'(REC_BASE)) >> SLOT_SH);

   always_comb begin
      rd_next = '0;
      if (rd_addr[1:0] == 2'b00) begin
         if (in_rec) begin
            case (rd_addr[SLOT_SH-1:2])
               '0:      rd_next = rd_rec.ts;
               'd1:     rd_next = rd_rec.rel;
               default: rd_next = '0;
            endcase
         end else begin
            case (rd_addr)
               ADDR_W'('h000): rd_next = pid_word;
               ADDR_W'('h004): rd_next = base_pc;
               ADDR_W'('h008): rd_next = TT_W'(head);
               ADDR_W'('h00C): rd_next = TT_W'(tail);
               ADDR_W'('h010): rd_next = {{(TT_W-1){1'b0}}, ovf};
               default:        rd_next = '0;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_next;
   end
endmodule

// File: rtl/tt_capture_chk.sv
module tt_capture_chk #(
   parameter int PID_W   = 16,
   parameter int N_SLOTS = 118,
   parameter int IDX_W   = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             evt_valid,
   input logic [4:0]       evt_code,
   input logic [PID_W-1:0] evt_pid,
   input logic             owned,
   input logic [PID_W-1:0] owner_pid,
   input logic             trace_on,
   input logic [IDX_W-1:0] head,
   input logic             ovf
);
   assert_head_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(head) < N_SLOTS);

   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   assert_drop_keeps_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $stable(head));

   assert_foreign_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && owned && evt_pid != owner_pid) |=>
         ($stable(trace_on) && $stable(head) && $stable(owner_pid)));

   assert_stopped_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 5'd4 && !trace_on) |=> $stable(head));

   assert_noop_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && (evt_code == 5'd0 || evt_code > 5'd4)) |=>
         ($stable(trace_on) && $stable(head) && $stable(owned) && $stable(owner_pid)));
endmodule

bind tt_capture tt_capture_chk #(.PID_W(PID_W), .N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .evt_valid (evt_valid),
   .evt_code  (evt_code),
   .evt_pid   (evt_pid),
   .owned     (owned),
   .owner_pid (owner_pid),
   .trace_on  (trace_on),
   .head      (head),
   .ovf       (ovf)
);

// File: tb/tt_capture_tb.sv
module tt_capture_tb;
   localparam int NS = 118;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [4:0]  evt_code = '0;
   logic [31:0] evt_pc = '0;
   logic [15:0] evt_pid = '0;
   logic [31:0] tstamp = '0;
   logic        rd_en = 1'b0;
   logic [11:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic        tail_we = 1'b0;
   logic [31:0] tail_wdata = '0;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   bit          m_own, m_en, m_ovf;
   logic [15:0] m_pid;
   logic [31:0] m_base;
   int          m_head, m_tail;
   logic [31:0] m_ts  [NS];
   logic [31:0] m_rel [NS];
   bit          m_wr  [NS];

   tt_capture u_dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
      .evt_pc(evt_pc), .evt_pid(evt_pid), .tstamp(tstamp), .rd_en(rd_en),
      .rd_addr(rd_addr), .rd_data(rd_data), .tail_we(tail_we), .tail_wdata(tail_wdata)
   );

   always #2 clk = ~clk;
   always @(posedge clk) tstamp <= tstamp + 32'd1;

   function automatic int nxt(int i);
      return (i == NS - 1) ? 0 : i + 1;
   endfunction

   task automatic ev(input logic [4:0] code, input logic [31:0] pc, input logic [15:0] pid);
      bit ok;
      @(negedge clk);
      evt_valid = 1'b1; evt_code = code; evt_pc = pc; evt_pid = pid;
      ok = !m_own || (pid == m_pid);
      if (ok) begin
         case (code)
            5'd1: begin m_own = 1; m_pid = pid; m_base = pc; end
            5'd2: m_en = 1;
            5'd3: m_en = 0;
            5'd4: if (m_en) begin
               if (nxt(m_head) == m_tail) m_ovf = 1;
               else begin
                  m_ts[m_head] = tstamp; m_rel[m_head] = pc - m_base;
                  m_wr[m_head] = 1; m_head = nxt(m_head);
               end
            end
            default: ;
         endcase
      end
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic set_tail(input logic [31:0] v);
      @(negedge clk);
      tail_we = 1'b1; tail_wdata = v;
      if (v < NS) m_tail = int'(v);
      @(negedge clk);
      tail_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      n_run++;
      if (d !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%h actual=%h expected=%h", req, a, d, exp);
      end
   endtask

   task automatic chk_hdr(input string req);
      chk(req, 12'h000, {16'h0, m_pid});
      chk(req, 12'h004, m_base);
      chk(req, 12'h008, 32'(m_head));
      chk(req, 12'h00C, 32'(m_tail));
      chk(req, 12'h010, {31'h0, m_ovf});
   endtask

   function automatic logic [11:0] slot_a(int s, int w);
      return 12'(32'h8A0 + 16 * s + 4 * w);
   endfunction

   initial begin
      int seed;
      int k;
      logic [31:0] d;
      seed = 32'h1234_5678;
      void'($urandom(seed));
      m_own = 0; m_en = 0; m_ovf = 0; m_pid = '0; m_base = '0; m_head = 0; m_tail = 0;
      for (int i = 0; i < NS; i++) m_wr[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      chk_hdr("R9 reset");
      chk("R10 unmapped", 12'h100, 32'h0);

      ev(5'd1, 32'h0000_4000, 16'd7);
      chk("R2 pid", 12'h000, 32'd7);
      chk("R2 base", 12'h004, 32'h0000_4000);

      ev(5'd2, 32'h4010, 16'd9);
      ev(5'd4, 32'h4020, 16'd7);
      chk("R3 foreign start ignored", 12'h008, 32'd0);

      ev(5'd0, 32'h4030, 16'd7);
      ev(5'd5, 32'h4030, 16'd7);
      ev(5'd31, 32'h4030, 16'd7);
      ev(5'd4, 32'h4040, 16'd7);
      chk_hdr("R1 noop codes");

      ev(5'd2, 32'h4050, 16'd7);
      ev(5'd4, 32'h0000_3FF0, 16'd7);
      chk("R4 ts", slot_a(0, 0), m_ts[0]);
      chk("R4 rel negative", slot_a(0, 1), 32'hFFFF_FFF0);
      chk("R4 pad8", slot_a(0, 2), 32'h0);
      chk("R4 pad12", slot_a(0, 3), 32'h0);
      chk("R4 head", 12'h008, 32'd1);
      chk("R10 misaligned", 12'h8A2, 32'h0);

      ev(5'd1, 32'h9999_0000, 16'd9);
      chk("R11 other claim pid", 12'h000, 32'd7);
      chk("R11 other claim base", 12'h004, 32'h0000_4000);
      ev(5'd4, 32'h4100, 16'd9);
      chk("R3 foreign mark", 12'h008, 32'd1);

      ev(5'd3, 32'h4060, 16'd7);
      ev(5'd4, 32'h4070, 16'd7);
      chk("R5 stopped mark", 12'h008, 32'd1);

      ev(5'd2, 32'h4080, 16'd7);
      for (int i = 0; i < 116; i++) ev(5'd4, 32'h4000 + 32'(4 * i), 16'd7);
      chk("R7 full head", 12'h008, 32'd117);
      chk("R7 no ovf yet", 12'h010, 32'd0);
      ev(5'd4, 32'h5000, 16'd7);
      chk("R7 drop head", 12'h008, 32'd117);
      chk("R7 ovf set", 12'h010, 32'd1);

      set_tail(32'd200);
      chk("R8 big tail ignored", 12'h00C, 32'd0);
      set_tail(32'd50);
      chk("R8 tail", 12'h00C, 32'd50);
      ev(5'd4, 32'h6000, 16'd7);
      chk("R6 wrap", 12'h008, 32'd0);
      chk("R6 last slot rel", slot_a(117, 1), 32'h2000);
      chk("R7 sticky", 12'h010, 32'd1);

      ev(5'd1, 32'h0001_0000, 16'd7);
      chk("R11 owner reclaim base", 12'h004, 32'h0001_0000);

      for (int i = 0; i < 500; i++) begin
         k = $urandom_range(0, 9);
         if (k < 7)
            ev((k < 5) ? 5'($urandom_range(1, 4)) : 5'($urandom_range(0, 31)),
               $urandom, ($urandom_range(0, 3) == 0) ? 16'd9 : 16'd7);
         else if (k == 7)
            set_tail(($urandom_range(0, 7) == 0) ? 32'd300 : 32'(m_head));
         else begin
            rd(12'h008, d);
            n_run++;
            if (d !== 32'(m_head)) begin
               n_fail++;
               $display("FAIL R4 random head actual=%h expected=%h", d, m_head);
            end
         end
      end
      chk_hdr("R8 random header");
      for (int s = 0; s < NS; s++) if (m_wr[s]) begin
         chk("R4 random ts", slot_a(s, 0), m_ts[s]);
         chk("R4 random rel", slot_a(s, 1), m_rel[s]);
      end

      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule